// File: doc/BRIEF.md
# I2C Target Controller with Host Register Access

This block is an I2C target (slave) that a host processor runs through three 32-bit word registers on a simple synchronous bus. The host programs a 7-bit bus address and turns the target on. The block then watches the bus for START and STOP conditions, compares the address byte that follows each START, and acknowledges when the address matches. Depending on the direction bit, it then receives bytes from the bus controller or sends bytes to it.

Every byte passes through one 8-bit data register as a handshake. When a byte arrives, the block raises a receive flag and holds SCL low until the host reads the byte. When the bus controller asks for data, the block raises a transmit flag and holds SCL low until the host writes the next byte. A first-byte flag marks the byte that comes straight after the address, so the host can tell a register index from a payload. The bus lines are driven as open-drain: each output is an enable that pulls the wire low.

Top module: `i2c_target_mmio`

## Requirements
- R1: After reset, all three registers read 0, and both `scl_oe` and `sda_oe` are 0 (the lines are released).
- R2: Offset 0x0 holds the own bus address in bits 6:0, which the host can read and write. Bits 31:7 always read 0.
- R3: A read of offset 0x4 returns the receive flag in bit 0, the transmit flag in bit 1 and the first-byte flag in bit 2, with all other bits 0. A write to offset 0x4 sets the enable from bit 0 (1 = on). The receive and transmit flags are never both set.
- R4: The address byte is bits 7:1 of address plus a direction bit in bit 0 (1 = target sends), sent MSB first. When the block is enabled and the address matches, it pulls SDA low on the 9th clock. On a mismatch, or while the block is disabled, it gives no ACK, raises no flag, leaves the data register unchanged and ignores the bus until the next START.
- R5: When a data byte has been received, the receive flag is set and SCL is held low until the host reads offset 0x8. That read returns the byte, clears the flag, and the block then acknowledges the byte on the 9th clock.
- R6: The first-byte flag is set together with the receive flag only for the first data byte after an address match. It is cleared by the read of offset 0x8.
- R7: When addressed for a read, the transmit flag is set and SCL is held low until the host writes offset 0x8. That write clears the flag, and bits 7:0 of the written word are sent MSB first.
- R8: The first-byte flag is never set while the block is sending.
- R9: After a sent byte, an ACK from the bus controller raises the transmit flag again. A NACK ends the transfer: no flag is raised, and both lines are released.
- R10: A START (SDA falling while SCL is high) restarts address matching from any state, including in the middle of a transfer, so a repeated START can switch direction. A STOP (SDA rising while SCL is high) returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle (a read of the data register has side effects) |
| bus_addr | input | 4 | Host byte offset (0x0, 0x4, 0x8) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from `bus_addr` |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The hardest thing to show from the ports is that the block really holds the clock. The bus controller lets go of SCL during every stretch, so the wire stays low only because of the target. The bench therefore has a host model that waits a fixed window after each flag before it services the register, and checks that SCL stays low for that whole window. A repeated START sequence (write, restart into a second write, then restart into a read that ends with a NACK) shows the first-byte flag coming back after each restart and the direction changing in the middle of a transfer.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
// Shared types and register offsets for the I2C target controller.
// Assumes byte offsets on a word-aligned host bus.
package i2c_tgt_pkg;

    // Host-visible register offsets
    localparam int unsigned OFS_OWN  = 0;
    localparam int unsigned OFS_STAT = 4;
    localparam int unsigned OFS_DATA = 8;

    // Bit positions inside the status word
    localparam int unsigned STAT_RX  = 0;
    localparam int unsigned STAT_TX  = 1;
    localparam int unsigned STAT_FB  = 2;

    // Byte engine states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_BYTE,
        ST_RX_HOLD,
        ST_RX_ACK,
        ST_TX_HOLD,
        ST_TX_SETUP,
        ST_TX_BYTE,
        ST_TX_ACK,
        ST_IGNORE
    } eng_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous wire levels.
// Assumes that the inputs idle high, so the stages reset to all ones.
module i2c_tgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stage_q[i] <= stage_q[i-1];
            end
            stage_q[0] <= d_in;
        end
    end

    assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_linemon.sv
`timescale 1ns/1ps
// Turns synchronized SCL/SDA levels into single-cycle events: clock edges,
// START and STOP. Assumes the inputs are already synchronized.
module i2c_tgt_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Keep the previous level of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and bus conditions from the current and previous levels
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
// Bit and byte sequencer of the I2C target. It matches the address, shifts
// data in or out, drives ACK, holds SCL low while a byte waits for the host,
// and keeps the receive, transmit and first-byte flags.
// Assumes that the event inputs come from i2c_tgt_linemon and that the host
// strobes last one cycle.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADDR_BITS = BYTE_W - 1,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 sda_s,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 dev_active,
    input  logic                 host_rd_data,
    input  logic                 host_wr_data,
    input  logic [BYTE_W-1:0]    host_wdata,
    output logic                 rx_load,
    output logic [BYTE_W-1:0]    rx_byte,
    output logic                 rreq,
    output logic                 treq,
    output logic                 fbr,
    output logic                 scl_oe,
    output logic                 sda_oe
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    eng_state_t        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              dir_rd;
    logic              first_pend;
    logic              mst_ack;

    // A completed receive byte is handed to the data register
    assign rx_load = (state == ST_RX_BYTE) && scl_fall && (bitcnt == CNT_FULL);
    assign rx_byte = shreg;

    // State, shift register and flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            dir_rd     <= 1'b0;
            first_pend <= 1'b0;
            mst_ack    <= 1'b0;
            rreq       <= 1'b0;
            treq       <= 1'b0;
            fbr        <= 1'b0;
        end else begin
            if (host_rd_data) begin
                rreq <= 1'b0;
                fbr  <= 1'b0;
            end
            if (host_wr_data) begin
                treq <= 1'b0;
            end

            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise && bitcnt != CNT_FULL) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_FULL) begin
                            if (dev_active && shreg[BYTE_W-1:1] == own_addr) begin
                                state  <= ST_ADDR_ACK;
                                dir_rd <= shreg[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (dir_rd) begin
                                state <= ST_TX_HOLD;
                                treq  <= 1'b1;
                            end else begin
                                state      <= ST_RX_BYTE;
                                first_pend <= 1'b1;
                            end
                        end
                    end
                    ST_RX_BYTE: begin
                        if (scl_rise && bitcnt != CNT_FULL) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (rx_load) begin
                            state      <= ST_RX_HOLD;
                            rreq       <= 1'b1;
                            fbr        <= first_pend;
                            first_pend <= 1'b0;
                        end
                    end
                    ST_RX_HOLD: begin
                        if (host_rd_data) begin
                            state <= ST_RX_ACK;
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_RX_BYTE;
                            bitcnt <= '0;
                        end
                    end
                    ST_TX_HOLD: begin
                        if (host_wr_data) begin
                            shreg  <= host_wdata;
                            bitcnt <= '0;
                            state  <= ST_TX_SETUP;
                        end
                    end
                    ST_TX_SETUP: begin
                        state <= ST_TX_BYTE;
                    end
                    ST_TX_BYTE: begin
                        if (scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == CNT_LAST) begin
                                state <= ST_TX_ACK;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                state <= ST_TX_HOLD;
                                treq  <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Open-drain enables follow the state
    always_comb begin
        scl_oe = (state == ST_RX_HOLD) || (state == ST_TX_HOLD) || (state == ST_TX_SETUP);
        sda_oe = (state == ST_ADDR_ACK) || (state == ST_RX_HOLD) || (state == ST_RX_ACK) ||
                 (((state == ST_TX_SETUP) || (state == ST_TX_BYTE)) && !shreg[BYTE_W-1]);
    end

endmodule

// File: rtl/i2c_tgt_csr.sv
`timescale 1ns/1ps
// Host register file: own address, enable and status, and the data byte.
// The data register is loaded by the engine when a byte arrives and by the
// host before a byte is sent. Read data is combinational from the offset.
module i2c_tgt_csr
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 4,
    parameter int BYTE_W = 8,
    localparam int ADDR_BITS = BYTE_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [OFS_W-1:0]     addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic                 rx_load,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic                 rreq,
    input  logic                 treq,
    input  logic                 fbr,
    output logic [ADDR_BITS-1:0] own_addr,
    output logic                 dev_active,
    output logic                 host_rd_data,
    output logic                 host_wr_data,
    output logic [BYTE_W-1:0]    host_wdata
);

    localparam logic [OFS_W-1:0] A_OWN  = OFS_W'(OFS_OWN);
    localparam logic [OFS_W-1:0] A_STAT = OFS_W'(OFS_STAT);
    localparam logic [OFS_W-1:0] A_DATA = OFS_W'(OFS_DATA);

    logic [BYTE_W-1:0] data_q;
    logic              unused_wbits;

    assign unused_wbits = &{1'b0, wdata[DATA_W-1:BYTE_W]};

    assign host_rd_data = rd_en && (addr == A_DATA);
    assign host_wr_data = wr_en && (addr == A_DATA);
    assign host_wdata   = wdata[BYTE_W-1:0];

    // Hold the address, enable and data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr   <= '0;
            dev_active <= 1'b0;
            data_q     <= '0;
        end else begin
            if (wr_en && addr == A_OWN) begin
                own_addr <= wdata[ADDR_BITS-1:0];
            end
            if (wr_en && addr == A_STAT) begin
                dev_active <= wdata[0];
            end
            if (rx_load) begin
                data_q <= rx_byte;
            end else if (host_wr_data) begin
                data_q <= host_wdata;
            end
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (addr == A_OWN) begin
            rdata[ADDR_BITS-1:0] = own_addr;
        end else if (addr == A_STAT) begin
            rdata[STAT_RX] = rreq;
            rdata[STAT_TX] = treq;
            rdata[STAT_FB] = fbr;
        end else if (addr == A_DATA) begin
            rdata[BYTE_W-1:0] = data_q;
        end
    end

endmodule

// File: rtl/i2c_target_mmio.sv
`timescale 1ns/1ps
// I2C target with host register access. It synchronizes the bus wires,
// detects bus events, runs the byte engine and exposes the registers.
// Assumes a system clock at least 8x SCL and open-drain wiring outside.
module i2c_target_mmio #(
    parameter int DATA_W      = 32,
    parameter int OFS_W       = 4,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_BITS  = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);

    logic                 scl_s;
    logic                 sda_s;
    logic                 scl_rise;
    logic                 scl_fall;
    logic                 start_det;
    logic                 stop_det;
    logic [ADDR_BITS-1:0] own_addr;
    logic                 dev_active;
    logic                 host_rd_data;
    logic                 host_wr_data;
    logic [BYTE_W-1:0]    host_wdata;
    logic                 rx_load;
    logic [BYTE_W-1:0]    rx_byte;
    logic                 rreq;
    logic                 treq;
    logic                 fbr;

    i2c_tgt_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_i, sda_i}),
        .q_out ({scl_s, sda_s})
    );

    i2c_tgt_linemon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(
        .BYTE_W (BYTE_W)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_s        (sda_s),
        .own_addr     (own_addr),
        .dev_active   (dev_active),
        .host_rd_data (host_rd_data),
        .host_wr_data (host_wr_data),
        .host_wdata   (host_wdata),
        .rx_load      (rx_load),
        .rx_byte      (rx_byte),
        .rreq         (rreq),
        .treq         (treq),
        .fbr          (fbr),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe)
    );

    i2c_tgt_csr #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W),
        .BYTE_W (BYTE_W)
    ) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr),
        .rd_en        (bus_rd),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .rdata        (bus_rdata),
        .rx_load      (rx_load),
        .rx_byte      (rx_byte),
        .rreq         (rreq),
        .treq         (treq),
        .fbr          (fbr),
        .own_addr     (own_addr),
        .dev_active   (dev_active),
        .host_rd_data (host_rd_data),
        .host_wr_data (host_wr_data),
        .host_wdata   (host_wdata)
    );

endmodule

// File: rtl/i2c_tgt_chk.sv
`timescale 1ns/1ps
// Property checker for the I2C target; attached to the top by bind.
module i2c_tgt_chk (
    input logic clk,
    input logic rst_n,
    input logic rreq,
    input logic treq,
    input logic fbr,
    input logic scl_oe,
    input logic rx_load,
    input logic host_rd_data,
    input logic host_wr_data
);

    // R3: receive and transmit flags never both set
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rreq, treq}));

    // R5: SCL is held low while a received byte waits for the host
    a_r5_rx_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        rreq |-> scl_oe);

    // R6: a data read clears the receive and first-byte flags
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data && !rx_load) |=> (!fbr && !rreq));

    // R7: SCL is held low while a transmit request is open
    a_r7_tx_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        treq |-> scl_oe);

    // R7: a data write clears an open transmit request
    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_data && treq) |=> !treq);

    // R8: first-byte flag only with a pending receive, never when sending
    a_r8_fbr_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
        fbr |-> (rreq && !treq));

endmodule

bind i2c_target_mmio i2c_tgt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rreq         (rreq),
    .treq         (treq),
    .fbr          (fbr),
    .scl_oe       (scl_oe),
    .rx_load      (rx_load),
    .host_rd_data (host_rd_data),
    .host_wr_data (host_wr_data)
);

// File: tb/i2c_target_mmio_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a bus controller model drives transfers and pushes the
// expected bytes; a host model services flags and compares them.
module i2c_target_mmio_test;

    localparam int Q     = 10;
    localparam int STALL = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        scl_oe;
    logic        sda_oe;
    logic        m_scl_drv = 1'b0;
    logic        m_sda_drv = 1'b0;
    logic        scl_line;
    logic        sda_line;

    int n_chk = 0;
    int n_err = 0;
    logic mon_en = 1'b0;
    logic done = 1'b0;

    logic [8:0] rx_exp_q[$];
    logic [7:0] tx_q[$];

    assign scl_line = !(m_scl_drv || scl_oe);
    assign sda_line = !(m_sda_drv || sda_oe);

    always #4 clk = ~clk;

    i2c_target_mmio uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Bus controller model: one clock pulse with a data bit
    task automatic m_bit(input logic b, output logic r);
        m_sda_drv = !b;
        wait_clk(Q);
        m_scl_drv = 1'b0;
        while (!scl_line) @(negedge clk);
        wait_clk(Q);
        r = sda_line;
        wait_clk(Q);
        m_scl_drv = 1'b1;
        wait_clk(Q);
    endtask

    task automatic m_start();
        m_sda_drv = 1'b0;
        wait_clk(Q);
        m_scl_drv = 1'b0;
        while (!scl_line) @(negedge clk);
        wait_clk(Q);
        m_sda_drv = 1'b1;
        wait_clk(Q);
        m_scl_drv = 1'b1;
        wait_clk(Q);
    endtask

    task automatic m_stop();
        m_sda_drv = 1'b1;
        wait_clk(Q);
        m_scl_drv = 1'b0;
        while (!scl_line) @(negedge clk);
        wait_clk(Q);
        m_sda_drv = 1'b0;
        wait_clk(4 * Q);
    endtask

    task automatic m_write_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic m_read_byte(output logic [7:0] d, input logic give_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(!give_ack, r);
    endtask

    // Driver helpers: send address / data, pushing expectations
    task automatic send_addr(input logic [6:0] a, input logic rd, input logic exp_ack, input string req);
        logic ack;
        m_write_byte({a, rd}, ack);
        chk(ack == exp_ack, req, {31'b0, ack}, {31'b0, exp_ack});
    endtask

    task automatic send_data(input logic [7:0] b, input logic first);
        logic ack;
        rx_exp_q.push_back({first, b});
        m_write_byte(b, ack);
        chk(ack == 1'b1, "R5 data ack", {31'b0, ack}, 32'd1);
    endtask

    task automatic recv_data(input logic [7:0] exp, input logic give_ack);
        logic [7:0] d;
        m_read_byte(d, give_ack);
        chk(d == exp, "R7 sent byte", {24'b0, d}, {24'b0, exp});
    endtask

    // Checks that SCL stays low for the whole service delay
    task automatic stall_check(input string req);
        bit low_ok = 1'b1;
        repeat (STALL) begin
            @(negedge clk);
            if (scl_line) low_ok = 1'b0;
        end
        chk(low_ok, req, {31'b0, !low_ok}, 32'd0);
    endtask

    // Host model / monitor: services flags and compares with the scoreboard
    initial begin
        logic [31:0] st;
        logic [31:0] d;
        logic [8:0]  e;
        forever begin
            if (mon_en) begin
                host_read(4'h4, st);
                if (st[0]) begin
                    stall_check("R5 stretch until read");
                    host_read(4'h8, d);
                    if (rx_exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected byte", d, 32'd0);
                    end else begin
                        e = rx_exp_q.pop_front();
                        chk(d[7:0] == e[7:0], "R5 received byte", d, {24'b0, e[7:0]});
                        chk(st[2] == e[8], "R6 first-byte flag", {31'b0, st[2]}, {31'b0, e[8]});
                    end
                end else if (st[1]) begin
                    chk(st[2] == 1'b0, "R8 no first-byte flag when sending", st, 32'h2);
                    stall_check("R7 stretch until write");
                    if (tx_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected transmit request", st, 32'd0);
                        host_write(4'h8, 32'hFF);
                    end else begin
                        host_write(4'h8, {24'b0, tx_q.pop_front()});
                    end
                end
            end else begin
                @(negedge clk);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1..R10 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic mon_off();
        mon_en = 1'b0;
        wait_clk(6);
    endtask

    // Main sequence
    initial begin
        logic [31:0] d;
        logic        ack;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset values
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {30'b0, scl_oe, sda_oe}, 32'd0);
        host_read(4'h0, d); chk(d == 32'd0, "R1 own address reset", d, 32'd0);
        host_read(4'h4, d); chk(d == 32'd0, "R1 status reset", d, 32'd0);
        host_read(4'h8, d); chk(d == 32'd0, "R1 data reset", d, 32'd0);

        // R2: own address width
        host_write(4'h0, 32'hFFFF_FFFF);
        host_read(4'h0, d); chk(d == 32'h7F, "R2 upper bits read zero", d, 32'h7F);
        host_write(4'h0, 32'h3C);
        host_read(4'h0, d); chk(d == 32'h3C, "R2 address readback", d, 32'h3C);

        // R4: disabled block gives no ACK
        m_start();
        send_addr(7'h3C, 1'b0, 1'b0, "R4 no ACK while disabled");
        m_stop();
        host_read(4'h4, d); chk(d == 32'd0, "R4 no flag while disabled", d, 32'd0);

        // R4: wrong address ignored, including a following byte
        host_write(4'h4, 32'h1);
        m_start();
        send_addr(7'h3D, 1'b0, 1'b0, "R4 no ACK on mismatch");
        m_write_byte(8'h00, ack);
        chk(ack == 1'b0, "R4 bus ignored after mismatch", {31'b0, ack}, 32'd0);
        m_stop();
        host_read(4'h4, d); chk(d == 32'd0, "R4 no flag on mismatch", d, 32'd0);
        host_read(4'h8, d); chk(d == 32'd0, "R4 data unchanged", d, 32'd0);

        // R5/R6: multi-byte write
        mon_en = 1'b1;
        m_start();
        send_addr(7'h3C, 1'b0, 1'b1, "R4 ACK on match");
        send_data(8'hA5, 1'b1);
        send_data(8'h5A, 1'b0);
        send_data(8'hFF, 1'b0);
        m_stop();
        mon_off();
        chk(rx_exp_q.size() == 0, "R5 all bytes serviced", rx_exp_q.size(), 32'd0);
        host_read(4'h8, d); chk(d == 32'hFF, "R5 data holds last byte", d, 32'hFF);

        // R7/R9: read of three bytes, last one NACKed
        tx_q.push_back(8'hC3); tx_q.push_back(8'h81); tx_q.push_back(8'h7E);
        mon_en = 1'b1;
        m_start();
        send_addr(7'h3C, 1'b1, 1'b1, "R4 ACK on read address");
        recv_data(8'hC3, 1'b1);
        recv_data(8'h81, 1'b1);
        recv_data(8'h7E, 1'b0);
        wait_clk(8 * Q);
        mon_off();
        host_read(4'h4, d); chk(d == 32'd0, "R9 no request after NACK", d, 32'd0);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 lines released after NACK", {30'b0, scl_oe, sda_oe}, 32'd0);
        chk(tx_q.size() == 0, "R9 requests match ACKed bytes", tx_q.size(), 32'd0);
        m_stop();

        // R10: repeated STARTs: write, write, read
        tx_q.push_back(8'h99);
        mon_en = 1'b1;
        m_start();
        send_addr(7'h3C, 1'b0, 1'b1, "R10 first address");
        send_data(8'h11, 1'b1);
        m_start();
        send_addr(7'h3C, 1'b0, 1'b1, "R10 address after restart");
        send_data(8'h22, 1'b1);
        m_start();
        send_addr(7'h3C, 1'b1, 1'b1, "R10 read after restart");
        recv_data(8'h99, 1'b0);
        m_stop();
        mon_off();
        chk(rx_exp_q.size() == 0 && tx_q.size() == 0, "R10 scoreboard drained",
            rx_exp_q.size() + tx_q.size(), 32'd0);
        host_read(4'h4, d); chk(d == 32'd0, "R10 idle after STOP", d, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule